// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Unit

This block is a SIMD integer datapath on a 256-bit vector, split into eight 32-bit lanes. In each lane it multiplies small sub-elements of operand A with the matching sub-elements of operand B. It then adds the products to that lane's 32-bit accumulator. There are two element modes. Byte mode forms four 8-bit products per lane, with A bytes taken as unsigned and B bytes as signed. Word mode forms two 16x16 products per lane, with both operands signed. The accumulation either wraps modulo 2^32 or clamps to the signed 32-bit range.

A width input selects the narrow form, which computes only the lower four lanes and returns zero in the upper 128 result bits. The block is meant to sit in a vector execution pipe. Operands arrive together with a valid strobe, and the result leaves through one optional pipeline register. A parameter can bypass that register.

Top module: `vec_dot_acc`

## Requirements
- R1: In byte mode, lane j (bits 32j+31..32j) adds four products to its accumulator. Byte k of the lane occupies bits 32j+8k+7..32j+8k. Each product is the A byte read as unsigned (0..255) times the B byte read as signed (-128..127).
- R2: In word mode, lane j adds two products to its accumulator. Word k of the lane occupies bits 32j+16k+15..32j+16k. Each product is a signed 16-bit A word times a signed 16-bit B word.
- R3: Without saturation, each lane result is the low 32 bits of the exact sum, so it wraps modulo 2^32.
- R4: With saturation, the exact sum (accumulator plus all products) is clamped to [-2^31, 2^31-1]. For example, in word mode two (-32768)x(-32768) products with a zero accumulator give 0x7FFFFFFF.
- R5: The 2-bit opcode is decoded as follows. Bit 0 selects the element mode: 0 for byte, 1 for word. Bit 1 enables saturation.
- R6: With `wide`=1, all eight lanes are computed. With `wide`=0, only lanes 0..3 are computed and result bits 255..128 are zero.
- R7: With the output register enabled (default), `out_valid` equals `in_valid` delayed by one clock, and the result of a valid input appears one clock later.
- R8: The output register loads only in a cycle where `in_valid` is 1. Otherwise `result` holds its previous value whatever the operand inputs do.
- R9: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.

Top module port order below follows the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| op | input | 2 | bit0 word mode, bit1 saturate |
| wide | input | 1 | 1 = 256-bit, 0 = 128-bit |
| acc_in | input | 256 | Eight 32-bit accumulators |
| a_in | input | 256 | Operand A (unsigned bytes / signed words) |
| b_in | input | 256 | Operand B (signed bytes / signed words) |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Eight 32-bit lane results |

## Verification
There are three places where a fault in this block can hide. The first is a lane's exact-sum width. Too narrow a sum makes saturation pick the wrong side, and the clamped or wrapped lane value appears at `result` one clock after the valid input. The second is a wrong signedness on a byte operand, which shows only when an A byte is 128 or more or a B byte is negative. For that reason the vectors drive 255 against -128 and 127 as well as full-scale words. The third is a wrong lane mask or a faulty register enable. These show as non-zero upper bits in narrow mode, or as a result that changes while `in_valid` is low, in the very next sampled cycle.

// File: rtl/vda_pkg.sv
package vda_pkg;
    localparam int LANE_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 16;
    localparam int BYTES_PL   = LANE_W / BYTE_W;
    localparam int WORDS_PL   = LANE_W / WORD_W;
    localparam int BPROD_W    = 2 * BYTE_W + 1;
    localparam int WPROD_W    = 2 * WORD_W;
    localparam int SUM_W      = LANE_W + 4;

    typedef struct packed {
        logic sat;
        logic word;
    } vda_op_t;
endpackage

// File: rtl/vda_lane.sv
module vda_lane
    import vda_pkg::*;
(
    input  logic              word_mode,
    input  logic              sat_mode,
    input  logic [LANE_W-1:0] acc,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] res
);
    localparam int BEXT = SUM_W - BPROD_W;
    localparam int WEXT = SUM_W - WPROD_W;
    localparam int AEXT = SUM_W - LANE_W;
    localparam logic signed [SUM_W-1:0] SMAX = {{(AEXT+1){1'b0}}, {(LANE_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SMIN = {{(AEXT+1){1'b1}}, {(LANE_W-1){1'b0}}};

    logic signed [BPROD_W-1:0] bprod [BYTES_PL];
    logic signed [WPROD_W-1:0] wprod [WORDS_PL];
    logic signed [SUM_W-1:0]   sum_x;

    always_comb begin
        for (int k = 0; k < BYTES_PL; k++) begin
            bprod[k] = $signed({1'b0, a[k*BYTE_W +: BYTE_W]}) * $signed(b[k*BYTE_W +: BYTE_W]);
        end
        for (int k = 0; k < WORDS_PL; k++) begin
            wprod[k] = $signed(a[k*WORD_W +: WORD_W]) * $signed(b[k*WORD_W +: WORD_W]);
        end
    end

    always_comb begin
        sum_x = {{AEXT{acc[LANE_W-1]}}, acc};
        if (word_mode) begin
            for (int k = 0; k < WORDS_PL; k++) begin
                sum_x = sum_x + {{WEXT{wprod[k][WPROD_W-1]}}, wprod[k]};
            end
        end else begin
            for (int k = 0; k < BYTES_PL; k++) begin
                sum_x = sum_x + {{BEXT{bprod[k][BPROD_W-1]}}, bprod[k]};
            end
        end
    end

    always_comb begin
        res = sum_x[LANE_W-1:0];
        if (sat_mode) begin
            if (sum_x > SMAX)      res = SMAX[LANE_W-1:0];
            else if (sum_x < SMIN) res = SMIN[LANE_W-1:0];
        end
    end

    always_comb begin
        if (sat_mode) begin
            AST_SAT_SIGN: assert (res[LANE_W-1] == sum_x[SUM_W-1]); // R4
        end
        if (!word_mode && b == '0) begin
            AST_ZERO_B_PASS: assert (res == acc); // R1
        end
    end
endmodule

// File: rtl/vda_out_reg.sv
module vda_out_reg #(
    parameter int W    = 256,
    parameter bit PIPE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } ost_t;

    generate
        if (PIPE) begin : g_reg
            ost_t st_d, st_q;

            always_comb begin
                st_d     = st_q;
                st_d.vld = in_valid;
                if (in_valid) st_d.data = in_data;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign out_valid = st_q.vld;
            assign out_data  = st_q.data;

            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_data)); // R8
        end else begin : g_bypass
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end
    endgenerate
endmodule

// File: rtl/vec_dot_acc.sv
module vec_dot_acc
    import vda_pkg::*;
#(
    parameter int LANES = 8,
    parameter bit PIPE  = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              op,
    input  logic                    wide,
    input  logic [LANES*LANE_W-1:0] acc_in,
    input  logic [LANES*LANE_W-1:0] a_in,
    input  logic [LANES*LANE_W-1:0] b_in,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] result
);
    localparam int VEC_W  = LANES * LANE_W;
    localparam int HALF_L = LANES / 2;
    localparam int HALF_W = HALF_L * LANE_W;

    vda_op_t              op_s;
    logic [LANE_W-1:0]    lane_res [LANES];
    logic [VEC_W-1:0]     comb_res;

    assign op_s = vda_op_t'(op);

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            vda_lane u_lane (
                .word_mode (op_s.word),
                .sat_mode  (op_s.sat),
                .acc       (acc_in[j*LANE_W +: LANE_W]),
                .a         (a_in[j*LANE_W +: LANE_W]),
                .b         (b_in[j*LANE_W +: LANE_W]),
                .res       (lane_res[j])
            );
            if (j < HALF_L) begin : g_low
                assign comb_res[j*LANE_W +: LANE_W] = lane_res[j];
            end else begin : g_high
                assign comb_res[j*LANE_W +: LANE_W] = wide ? lane_res[j] : '0;
            end
        end
    endgenerate

    vda_out_reg #(.W(VEC_W), .PIPE(PIPE)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (comb_res),
        .out_valid (out_valid),
        .out_data  (result)
    );

    generate
        if (PIPE) begin : g_chk
            AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid); // R7
            AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid); // R7
            AST_NARROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !wide) |=> (result[VEC_W-1:HALF_W] == '0)); // R6
        end
    endgenerate
endmodule

// File: tb/vec_dot_acc_tb_top.sv
module vec_dot_acc_tb_top;
    localparam int VW = 256;
    localparam int NT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    op = 2'b00;
    logic          wide = 1'b1;
    logic [VW-1:0] acc_in = '0, a_in = '0, b_in = '0;
    logic          out_valid;
    logic [VW-1:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vec_dot_acc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
        .acc_in(acc_in), .a_in(a_in), .b_in(b_in),
        .out_valid(out_valid), .result(result)
    );

    // op bit0 = word, bit1 = saturate; each row broadcast to all lanes, wide mode
    localparam logic [1:0]  T_OP  [NT] = '{2'd0, 2'd0, 2'd1, 2'd3, 2'd2,
                                           2'd0, 2'd2, 2'd3, 2'd1, 2'd0};
    localparam logic [31:0] T_ACC [NT] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h7FFFFFF0,
                                           32'h7FFFFFF0, 32'h80000010, 32'h80000000, 32'd100, 32'd5};
    localparam logic [31:0] T_A   [NT] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80008000, 32'h80008000, 32'hFFFFFFFF,
                                           32'hFFFFFFFF, 32'hFFFFFFFF, 32'h7FFF8000, 32'h00020003, 32'h01020304};
    localparam logic [31:0] T_B   [NT] = '{32'h80808080, 32'h7F7F7F7F, 32'h80008000, 32'h80008000, 32'h7F7F7F7F,
                                           32'h7F7F7F7F, 32'h80808080, 32'h80007FFF, 32'hFFFF0004, 32'hFF02FD04};
    localparam logic [31:0] T_EXP [NT] = '{32'hFFFE0200,  // R1 unsigned A x signed B
                                           32'h0001FA04,  // R1
                                           32'h80000000,  // R3 word wrap of 2^31
                                           32'h7FFFFFFF,  // R4 word clamp high
                                           32'h7FFFFFFF,  // R4 byte clamp high
                                           32'h8001F9F4,  // R3 byte wrap
                                           32'h80000000,  // R4 byte clamp low
                                           32'h80000000,  // R4 word clamp low
                                           32'h0000006E,  // R2 mixed sign words
                                           32'h0000000F}; // R5 byte decode

    function automatic logic [VW-1:0] bcast(logic [31:0] v);
        return {8{v}};
    endfunction

    function automatic logic [VW-1:0] model(logic [1:0] o, logic w,
                                            logic [VW-1:0] s, logic [VW-1:0] a, logic [VW-1:0] b);
        logic [VW-1:0] r;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            longint t;
            t = longint'($signed(s[32*j +: 32]));
            if (o[0]) begin
                for (int k = 0; k < 2; k++)
                    t += longint'($signed(a[32*j+16*k +: 16])) * longint'($signed(b[32*j+16*k +: 16]));
            end else begin
                for (int k = 0; k < 4; k++)
                    t += longint'(a[32*j+8*k +: 8]) * longint'($signed(b[32*j+8*k +: 8]));
            end
            if (o[1]) begin
                if (t > 64'sd2147483647)   t = 64'sd2147483647;
                if (t < -64'sd2147483648)  t = -64'sd2147483648;
            end
            if (w || j < 4) r[32*j +: 32] = t[31:0];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] o, logic w, logic [VW-1:0] s, logic [VW-1:0] a, logic [VW-1:0] b);
        @(negedge clk);
        op = o; wide = w; acc_in = s; a_in = a; b_in = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [VW-1:0] hold_v;
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", {255'd0, out_valid}, '0);
        check("R9 reset result", result, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NT; i++) begin
            apply(T_OP[i], 1'b1, bcast(T_ACC[i]), bcast(T_A[i]), bcast(T_B[i]));
            check($sformatf("R1/R2/R3/R4/R5 table row %0d", i), result, bcast(T_EXP[i]));
        end

        // R7: valid strobe delayed by one clock
        @(negedge clk);
        in_valid = 1'b1; acc_in = bcast(32'd1); a_in = '0; b_in = '0; op = 2'd0; wide = 1'b1;
        @(negedge clk);
        check("R7 out_valid after in_valid", {255'd0, out_valid}, 256'd1);
        check("R7 result latency", result, bcast(32'd1));
        in_valid = 1'b0;
        hold_v = result;
        acc_in = bcast(32'h12345678); a_in = '1; b_in = '1; op = 2'd3;
        @(negedge clk);
        check("R7 out_valid low when idle", {255'd0, out_valid}, '0);
        check("R8 result held while idle", result, hold_v);

        // R6: narrow mode clears the upper half
        apply(2'd1, 1'b0, '0, bcast(32'h80008000), bcast(32'h80008000));
        check("R6 narrow word wrap", result, {128'd0, {4{32'h80000000}}});
        apply(2'd3, 1'b0, '0, bcast(32'h80008000), bcast(32'h80008000));
        check("R6 R4 narrow word clamp", result, {128'd0, {4{32'h7FFFFFFF}}});

        // R1 R2 R3 R4 R6: random operands against the reference
        for (int i = 0; i < 200; i++) begin
            logic [VW-1:0] s, a, b;
            logic [1:0] o;
            logic w;
            for (int k = 0; k < 8; k++) begin
                s[32*k +: 32] = $urandom;
                a[32*k +: 32] = $urandom;
                b[32*k +: 32] = $urandom;
            end
            if (i % 5 == 0) s = bcast(i % 2 == 0 ? 32'h7FFFFF00 : 32'h80000100);
            o = 2'($urandom_range(0, 3));
            w = 1'($urandom_range(0, 1));
            apply(o, w, s, a, b);
            check($sformatf("R1/R2 random op=%0d wide=%0d", o, w), result, model(o, w, s, a, b));
        end

        done = 1'b1;
        report();
    end
endmodule